// File: doc/BRIEF.md
# Register Window Control Unit

This block steers a windowed register file. It holds the current window pointer and the two availability counters: windows free to save into, and windows that can be restored. It carries out the four window operations: save, restore, return and flush-windows. For each operation it either moves the pointer and counters, or it raises a one-cycle trap request. The trap can be a spill, a fill, a clean-window or an alignment fault.

Spill and fill requests come in two variants. The variant depends on whether the other-window count is zero. The handler selector is taken from the matching half of a 6-bit window-state field. The pointer still moves on a save or restore that traps, so the handler runs in the window the operation was aiming for.

A trap-return load restores the pointer from a saved state word. The register storage and the trap handler sit outside this block. The other-window count, the clean-window count and the window-state field are supplied as inputs.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset (synchronous, `rst_n` low at a clock edge) the pointer is 0, `can_save` is NWIN-2, `can_restore` is 0 and `trap_valid` is low. Every pointer update wraps modulo NWIN (default 8).
- R2: A save (`op_code` 0) with `can_save` nonzero and `clean_win` different from `can_restore` advances the pointer by 1. It decrements `can_save`, increments `can_restore` and raises no trap.
- R3: A save with `can_save` equal to 0 advances the pointer by 2, leaves both counters unchanged and raises a spill trap.
- R4: A save with `can_save` nonzero and `clean_win` equal to `can_restore` advances the pointer by 1. It leaves the counters unchanged and raises a clean-window trap: `trap_kind` 5, `trap_sel` 0.
- R5: Spill and fill traps select their variant from `other_win`. When `other_win` is nonzero, spill is `trap_kind` 2 and fill is 4, and `trap_sel` is `win_state[5:3]`. When `other_win` is zero, spill is 1 and fill is 3, and `trap_sel` is `win_state[2:0]`.
- R6: A restore (`op_code` 1) always moves the pointer back by 1. If `can_restore` is 0, it raises a fill trap and leaves the counters unchanged. Otherwise it increments `can_save` and decrements `can_restore`.
- R7: A flush-windows (`op_code` 3) raises a spill trap exactly when NWIN-2 minus `can_save` is 0. It never changes the pointer or the counters.
- R8: A return (`op_code` 2) with `ret_lo` nonzero raises an alignment trap (`trap_kind` 6, `trap_sel` 0) and changes no window state. With `ret_lo` equal to 0 it behaves as a restore (R6).
- R9: A trap-return load (`tret_valid`) sets the pointer to `tret_lo` modulo NWIN. It leaves the counters unchanged and raises no trap. An operation strobed in the same cycle is discarded.
- R10: Outputs update on the clock edge that samples the operation. `trap_valid` is high for exactly the one cycle after each trapping operation, so back-to-back trapping operations give back-to-back pulses. It is low after any cycle with no operation. `trap_kind` is 0 whenever `trap_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Window operation strobe |
| op_code | input | 2 | 0 save, 1 restore, 2 return, 3 flush-windows |
| ret_lo | input | 2 | Low two bits of the return target address |
| other_win | input | CW | Other-window count |
| clean_win | input | CW | Clean-window count |
| win_state | input | 6 | Window-state field: [5:3] other selector, [2:0] normal selector |
| tret_valid | input | 1 | Trap-return load strobe |
| tret_lo | input | 5 | Bits 4:0 of the saved state word |
| cwp | output | CW | Current window pointer |
| can_save | output | CW | Windows available to save |
| can_restore | output | CW | Windows available to restore |
| trap_valid | output | 1 | Trap request, one cycle |
| trap_kind | output | 3 | 1/2 spill normal/other, 3/4 fill normal/other, 5 clean, 6 alignment |
| trap_sel | output | 3 | Handler selector from the window-state field |

## Verification
The trap-return load and a window operation can arrive in the same clock cycle. The bench provokes this with saves that would otherwise succeed or trap, and also through a pseudorandom run that sometimes raises both strobes together. The collision is judged by the pointer matching the loaded value, both counters keeping their old values and no trap pulse appearing. Checks against the bench's own model also confirm that the following operation sees the untouched counters.

// File: rtl/regwin_pkg.sv
// Package: shared encodings for the register window control unit.
// Assumes: op and trap codes are fixed by the block's port contract.
package regwin_pkg;

    typedef enum logic [1:0] {
        OP_SAVE    = 2'd0,
        OP_RESTORE = 2'd1,
        OP_RETURN  = 2'd2,
        OP_FLUSH   = 2'd3
    } win_op_t;

    typedef enum logic [2:0] {
        PS_HOLD = 3'd0,
        PS_INC1 = 3'd1,
        PS_INC2 = 3'd2,
        PS_DEC1 = 3'd3,
        PS_LOAD = 3'd4
    } ptr_step_t;

    typedef enum logic [1:0] {
        CA_NONE    = 2'd0,
        CA_SAVE    = 2'd1,
        CA_RESTORE = 2'd2
    } cnt_act_t;

    typedef enum logic [2:0] {
        TK_NONE    = 3'd0,
        TK_SPILL_N = 3'd1,
        TK_SPILL_O = 3'd2,
        TK_FILL_N  = 3'd3,
        TK_FILL_O  = 3'd4,
        TK_CLEAN   = 3'd5,
        TK_ALIGN   = 3'd6
    } trap_kind_t;

endpackage

// File: rtl/regwin_decide.sv
// Module: regwin_decide
// Combinational decision for one cycle. It picks the pointer step, the
// counter action and any trap from the operation and the current state.
// Assumes: at most one of op_fire and tret_fire is high (the top gives the
// load priority).
module regwin_decide
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW  = $clog2(NWIN)
) (
    input  logic          op_fire,
    input  logic [1:0]    op_code,
    input  logic [1:0]    ret_lo,
    input  logic          tret_fire,
    input  logic [CW-1:0] can_save,
    input  logic [CW-1:0] can_restore,
    input  logic [CW-1:0] other_win,
    input  logic [CW-1:0] clean_win,
    input  logic [5:0]    win_state,
    output ptr_step_t     step,
    output cnt_act_t      act,
    output logic          trap_fire,
    output trap_kind_t    trap_kind,
    output logic [2:0]    trap_sel
);

    localparam logic [CW-1:0] SAVE_FULL = CW'(NWIN - 2);

    win_op_t    op;
    logic       other_nz;
    logic [2:0] var_sel;
    trap_kind_t spill_kind;
    trap_kind_t fill_kind;

    assign op = win_op_t'(op_code);

    // Variant selection for spill and fill traps.
    always_comb begin
        other_nz   = |other_win;
        var_sel    = other_nz ? win_state[5:3] : win_state[2:0];
        spill_kind = other_nz ? TK_SPILL_O : TK_SPILL_N;
        fill_kind  = other_nz ? TK_FILL_O  : TK_FILL_N;
    end

    // Per-operation outcome: pointer step, counter action, trap.
    always_comb begin
        step      = PS_HOLD;
        act       = CA_NONE;
        trap_fire = 1'b0;
        trap_kind = TK_NONE;
        trap_sel  = 3'd0;
        if (tret_fire) begin
            step = PS_LOAD;
        end else if (op_fire) begin
            case (op)
                OP_SAVE: begin
                    if (can_save == '0) begin
                        step      = PS_INC2;
                        trap_fire = 1'b1;
                        trap_kind = spill_kind;
                        trap_sel  = var_sel;
                    end else if (clean_win == can_restore) begin
                        step      = PS_INC1;
                        trap_fire = 1'b1;
                        trap_kind = TK_CLEAN;
                    end else begin
                        step = PS_INC1;
                        act  = CA_SAVE;
                    end
                end
                OP_RESTORE, OP_RETURN: begin
                    if (op == OP_RETURN && ret_lo != 2'b00) begin
                        trap_fire = 1'b1;
                        trap_kind = TK_ALIGN;
                    end else begin
                        step = PS_DEC1;
                        if (can_restore == '0) begin
                            trap_fire = 1'b1;
                            trap_kind = fill_kind;
                            trap_sel  = var_sel;
                        end else begin
                            act = CA_RESTORE;
                        end
                    end
                end
                OP_FLUSH: begin
                    if (can_save == SAVE_FULL) begin
                        trap_fire = 1'b1;
                        trap_kind = spill_kind;
                        trap_sel  = var_sel;
                    end
                end
                default: begin
                    step = PS_HOLD;
                end
            endcase
        end
    end

    // A trap never pairs with a counter update in the same decision.
    always_comb begin
        assert_trap_no_count_R3 : assert (!(trap_fire && act != CA_NONE));
    end

endmodule

// File: rtl/regwin_ptr.sv
// Module: regwin_ptr
// Current window pointer register with modulo-NWIN step arithmetic.
// Assumes: NWIN >= 4 and NWIN <= 2**CW.
module regwin_ptr
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ptr_step_t     step,
    input  logic [4:0]    load_field,
    output logic [CW-1:0] cwp
);

    localparam logic [CW:0] NW_WIDE = (CW+1)'(NWIN);

    logic [CW:0]   sum2;
    logic [CW-1:0] nxt;

    // Next pointer value for each step kind, wrapped modulo NWIN.
    always_comb begin
        sum2 = {1'b0, cwp} + (CW+1)'(2);
        if (sum2 >= NW_WIDE) sum2 = sum2 - NW_WIDE;
        case (step)
            PS_INC1: nxt = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
            PS_INC2: nxt = sum2[CW-1:0];
            PS_DEC1: nxt = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);
            PS_LOAD: nxt = CW'(32'(load_field) % NWIN);
            default: nxt = cwp;
        endcase
    end

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) cwp <= '0;
        else        cwp <= nxt;
    end

    assert_ptr_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
        int'(cwp) < NWIN);

    assert_ptr_inc_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step) == PS_INC1
        |-> int'(cwp) == (int'($past(cwp)) + 1) % NWIN);

    assert_ptr_inc2_R3 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step) == PS_INC2
        |-> int'(cwp) == (int'($past(cwp)) + 2) % NWIN);

    assert_ptr_dec_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(step) == PS_DEC1
        |-> int'(cwp) == (int'($past(cwp)) + NWIN - 1) % NWIN);

endmodule

// File: rtl/regwin_cnt.sv
// Module: regwin_cnt
// Save-available and restore-available counter pair. A save moves one unit
// from can_save to can_restore, and a restore moves it back.
// Assumes: the decision logic never requests an action that would wrap.
module regwin_cnt
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_act_t      act,
    output logic [CW-1:0] can_save,
    output logic [CW-1:0] can_restore
);

    // Counter pair update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            can_save    <= CW'(NWIN - 2);
            can_restore <= '0;
        end else begin
            case (act)
                CA_SAVE: begin
                    can_save    <= can_save - CW'(1);
                    can_restore <= can_restore + CW'(1);
                end
                CA_RESTORE: begin
                    can_save    <= can_save + CW'(1);
                    can_restore <= can_restore - CW'(1);
                end
                default: begin
                    can_save    <= can_save;
                    can_restore <= can_restore;
                end
            endcase
        end
    end

    assert_pair_sum_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        int'(can_save) + int'(can_restore) == NWIN - 2);

    assert_pair_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(act) == CA_NONE
        |-> $stable(can_save) && $stable(can_restore));

endmodule

// File: rtl/regwin_trapreg.sv
// Module: regwin_trapreg
// Registers the trap request so that it is presented for one cycle after
// the operation that raised it.
// Assumes: kind is TK_NONE whenever fire is low.
module regwin_trapreg
    import regwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  trap_kind_t kind,
    input  logic [2:0] sel,
    output logic       trap_valid,
    output logic [2:0] trap_kind,
    output logic [2:0] trap_sel
);

    // One-cycle trap request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_valid <= 1'b0;
            trap_kind  <= 3'd0;
            trap_sel   <= 3'd0;
        end else begin
            trap_valid <= fire;
            trap_kind  <= fire ? kind : 3'd0;
            trap_sel   <= fire ? sel  : 3'd0;
        end
    end

    assert_trap_cause_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> $past(rst_n) && $past(fire));

    assert_trap_code_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid == (trap_kind != 3'd0));

endmodule

// File: rtl/regwin_ctrl.sv
// Module: regwin_ctrl (top)
// Register window control unit. It tracks the window pointer and the
// save/restore availability counters, and performs save, restore, return
// and flush-windows. It raises spill, fill, clean-window and alignment
// trap requests, and accepts a trap-return pointer load.
// Assumes: other_win, clean_win and win_state are stable in the operation
// cycle. A trap-return load takes priority over an operation in the same
// cycle.
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic [1:0]    ret_lo,
    input  logic [CW-1:0] other_win,
    input  logic [CW-1:0] clean_win,
    input  logic [5:0]    win_state,
    input  logic          tret_valid,
    input  logic [4:0]    tret_lo,
    output logic [CW-1:0] cwp,
    output logic [CW-1:0] can_save,
    output logic [CW-1:0] can_restore,
    output logic          trap_valid,
    output logic [2:0]    trap_kind,
    output logic [2:0]    trap_sel
);

    logic       op_fire;
    ptr_step_t  step;
    cnt_act_t   act;
    logic       d_fire;
    trap_kind_t d_kind;
    logic [2:0] d_sel;

    // Priority: a trap-return load discards a same-cycle operation.
    always_comb op_fire = op_valid && !tret_valid;

    regwin_decide #(.NWIN(NWIN)) u_decide (
        .op_fire     (op_fire),
        .op_code     (op_code),
        .ret_lo      (ret_lo),
        .tret_fire   (tret_valid),
        .can_save    (can_save),
        .can_restore (can_restore),
        .other_win   (other_win),
        .clean_win   (clean_win),
        .win_state   (win_state),
        .step        (step),
        .act         (act),
        .trap_fire   (d_fire),
        .trap_kind   (d_kind),
        .trap_sel    (d_sel)
    );

    regwin_ptr #(.NWIN(NWIN)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_field (tret_lo),
        .cwp        (cwp)
    );

    regwin_cnt #(.NWIN(NWIN)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .can_save    (can_save),
        .can_restore (can_restore)
    );

    regwin_trapreg u_trap (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (d_fire),
        .kind       (d_kind),
        .sel        (d_sel),
        .trap_valid (trap_valid),
        .trap_kind  (trap_kind),
        .trap_sel   (trap_sel)
    );

    assert_load_wins_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(tret_valid)
        |-> !trap_valid && int'(cwp) == int'($past(tret_lo)) % NWIN
            && $stable(can_save));

    assert_align_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_fire) && $past(op_code) == 2'd2 && $past(ret_lo) != 2'b00
        |-> trap_valid && trap_kind == 3'd6 && $stable(cwp) && $stable(can_restore));

    assert_flush_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(op_fire) && $past(op_code) == 2'd3
        |-> $stable(cwp) && $stable(can_save));

    assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(op_valid) |-> !trap_valid);

endmodule

// File: tb/regwin_ctrl_tb.sv
// Scoreboard bench: the driver computes expected outputs from a model and
// queues them, and the monitor pops and compares after each clock edge.
module regwin_ctrl_tb;

    localparam int N = 8;

    typedef struct {
        int    cwp;
        int    cs;
        int    cr;
        int    tv;
        int    kind;
        int    sel;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_code = 2'd0;
    logic [1:0] ret_lo = 2'd0;
    logic [2:0] other_win = 3'd0;
    logic [2:0] clean_win = 3'd0;
    logic [5:0] win_state = 6'd0;
    logic       tret_valid = 1'b0;
    logic [4:0] tret_lo = 5'd0;
    logic [2:0] cwp, can_save, can_restore;
    logic       trap_valid;
    logic [2:0] trap_kind, trap_sel;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;
    exp_t q[$];
    int   m_cwp, m_cs, m_cr;

    always #5 clk = ~clk;

    regwin_ctrl #(.NWIN(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .ret_lo(ret_lo), .other_win(other_win), .clean_win(clean_win),
        .win_state(win_state), .tret_valid(tret_valid), .tret_lo(tret_lo),
        .cwp(cwp), .can_save(can_save), .can_restore(can_restore),
        .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_sel(trap_sel)
    );

    task automatic check(int act, int exp, string what, string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(bit v, int op, int lo, int oth, int cln, int ws,
                        bit tl, int tlo, string tag);
        exp_t e;
        bit   do_fill;
        @(negedge clk);
        op_valid   = v;
        op_code    = 2'(op);
        ret_lo     = 2'(lo);
        other_win  = 3'(oth);
        clean_win  = 3'(cln);
        win_state  = 6'(ws);
        tret_valid = tl;
        tret_lo    = 5'(tlo);
        e.tv = 0; e.kind = 0; e.sel = 0; e.tag = tag;
        do_fill = 1'b0;
        if (tl) begin
            m_cwp = tlo % N;
        end else if (v) begin
            if (op == 0) begin
                if (m_cs == 0) begin
                    e.tv = 1; e.kind = (oth != 0) ? 2 : 1;
                    e.sel = (oth != 0) ? (ws >> 3) & 7 : ws & 7;
                    m_cwp = (m_cwp + 2) % N;
                end else if (cln == m_cr) begin
                    e.tv = 1; e.kind = 5;
                    m_cwp = (m_cwp + 1) % N;
                end else begin
                    m_cwp = (m_cwp + 1) % N; m_cs--; m_cr++;
                end
            end else if (op == 3) begin
                if (N - 2 - m_cs == 0) begin
                    e.tv = 1; e.kind = (oth != 0) ? 2 : 1;
                    e.sel = (oth != 0) ? (ws >> 3) & 7 : ws & 7;
                end
            end else if (op == 2 && lo != 0) begin
                e.tv = 1; e.kind = 6;
            end else begin
                do_fill = 1'b1;
            end
            if (do_fill) begin
                m_cwp = (m_cwp + N - 1) % N;
                if (m_cr == 0) begin
                    e.tv = 1; e.kind = (oth != 0) ? 4 : 3;
                    e.sel = (oth != 0) ? (ws >> 3) & 7 : ws & 7;
                end else begin
                    m_cs++; m_cr--;
                end
            end
        end
        e.cwp = m_cwp; e.cs = m_cs; e.cr = m_cr;
        q.push_back(e);
    endtask

    // Monitor: compares outputs shortly after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(int'(cwp), e.cwp, "cwp", e.tag);
            check(int'(can_save), e.cs, "can_save", e.tag);
            check(int'(can_restore), e.cr, "can_restore", e.tag);
            check(int'(trap_valid), e.tv, "trap_valid", e.tag);
            check(int'(trap_kind), e.kind, "trap_kind", e.tag);
            check(int'(trap_sel), e.sel, "trap_sel", e.tag);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Directed and pseudorandom stimulus.
    initial begin
        m_cwp = 0; m_cs = N - 2; m_cr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
        step(1, 1, 0, 0, 0, 6'o53, 0, 0, "R6 R5 fill normal");
        step(1, 3, 0, 0, 0, 6'o53, 0, 0, "R7 flush spill");
        step(1, 0, 0, 0, 5, 0, 0, 0, "R2 save ok");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 7, 0, 0, 0, "R2 save drain");
        step(1, 0, 0, 2, 7, 6'o64, 0, 0, "R3 R5 spill other");
        step(1, 2, 0, 0, 7, 0, 0, 0, "R8 aligned return");
        step(1, 0, 0, 0, 5, 0, 0, 0, "R4 clean window");
        step(1, 2, 2, 0, 0, 0, 0, 0, "R8 misaligned");
        step(1, 2, 1, 0, 0, 0, 0, 0, "R8 misaligned odd");
        step(1, 3, 0, 1, 0, 6'o77, 0, 0, "R7 flush no trap");
        step(1, 0, 0, 0, 7, 0, 1, 13, "R9 load beats save");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
        for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 0, 0, 0, 0, "R6 restore ok");
        step(1, 1, 0, 1, 0, 6'o25, 0, 0, "R6 R5 fill other");
        step(1, 0, 0, 0, 0, 0, 1, 31, "R9 load wrap");
        step(1, 3, 0, 0, 0, 6'o07, 0, 0, "R10 back-to-back a");
        step(1, 3, 0, 3, 0, 6'o70, 0, 0, "R10 back-to-back b");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10 quiet");
        for (int i = 0; i < 600; i++) begin
            int  lo;
            bit  v;
            bit  tl;
            lo = ($urandom % 3 == 0) ? int'($urandom % 4) : 0;
            v  = ($urandom % 5) != 0;
            tl = ($urandom % 12) == 0;
            step(v, int'($urandom % 4), lo, int'($urandom % 2) * 3,
                 int'($urandom % N), int'($urandom % 64), tl,
                 int'($urandom % 32), "R10 random");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10 final");
        while (q.size() > 0) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule